// File: doc/BRIEF.md
# Branch and Skip Next-PC Unit

This block works out where the program counter goes after one instruction of a small 8-bit processor core, and how many cycles that instruction takes. Each cycle it is given the current PC, the status register, a decoded operation, a signed jump displacement, a status bit selector, a tested-bit value, a flag for a following two-word instruction and the 16-bit Z pointer. One clock edge later it presents the next PC, a taken flag and the total cycle count.

It handles sequential flow, relative jump and call, indirect jump through Z, conditional branches on any status bit being set or clear, and skips over a following one-word or two-word instruction. Signed comparisons are expressed as a branch on the sign bit. The unit derives that bit from N XOR V and does not trust the stored copy. Stack handling, returns and fetch belong to the neighbouring blocks.

Top module: `npc_unit`

## Requirements
- R1: While rst_n is low, npc_o is 0, taken_o is 0 and cycles_o is 0.
- R2: Outputs are registered: they reflect the inputs sampled at the previous rising clock edge and hold steady between edges.
- R3: Operation code 0 (sequential) gives npc_o = pc + 1, taken_o = 0 and cycles_o = 1.
- R4: Code 1 (relative jump) and code 2 (relative call) give npc_o = pc + k + 1, where k is disp_i sign-extended, with taken_o = 1. cycles_o is 2 for the jump and 3 for the call.
- R5: Code 3 (indirect jump) gives npc_o = z_ptr_i, taken_o = 1 and cycles_o = 2.
- R6: Code 4 branches when the selected status bit is 1, and code 5 branches when it is 0. A taken branch gives pc + k + 1 with cycles_o = 2. A branch not taken gives pc + 1 with cycles_o = 1 and taken_o = 0.
- R7: The status register bits are C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7. When bit_sel_i is 4, the branch condition is sreg[2] XOR sreg[3] and the stored bit 4 is ignored. Signed greater-or-equal is therefore code 5 with selector 4, and signed less-than is code 4 with selector 4.
- R8: Code 6 skips when test_bit_i is 1, and code 7 skips when test_bit_i is 0. A skip gives pc + 2 with cycles_o = 2 if next_two_word_i is 0, or pc + 3 with cycles_o = 3 if it is 1. A skip not taken gives pc + 1 with cycles_o = 1 and taken_o = 0.
- R9: All PC arithmetic wraps modulo 2^16, for both positive and negative displacements.
- R10: next_two_word_i has no effect on any operation other than codes 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_i | input | 16 | Current program counter |
| sreg_i | input | 8 | Status register |
| op_i | input | 3 | Decoded operation code (0..7) |
| disp_i | input | 12 | Signed relative displacement |
| bit_sel_i | input | 3 | Status bit index for branches |
| test_bit_i | input | 1 | Tested-bit value for skips |
| next_two_word_i | input | 1 | Following instruction is two words long |
| z_ptr_i | input | 16 | Z pointer for indirect jump |
| npc_o | output | 16 | Next program counter |
| taken_o | output | 1 | Control flow left the sequential path |
| cycles_o | output | 2 | Cycles the instruction takes |

## Verification
The bench puts the stored sign bit in disagreement with N XOR V. A design that read bit 4 directly would take signed branches the wrong way. It uses the most negative displacement and crosses address zero in both directions, which catches zero-extension and carry faults. Skips over two-word instructions must add 3 and report 3 cycles; a unit that assumed one-word followers would land inside that instruction. It also toggles the two-word flag under jumps and sequential flow, and checks that outputs do not change before the clock edge, which would expose a leaking size flag or a combinational path.

// File: rtl/npc_pkg.sv
package npc_pkg;

    typedef enum logic [2:0] {
        OP_SEQ    = 3'd0,
        OP_RJMP   = 3'd1,
        OP_RCALL  = 3'd2,
        OP_IJMP   = 3'd3,
        OP_BR_SET = 3'd4,
        OP_BR_CLR = 3'd5,
        OP_SK_SET = 3'd6,
        OP_SK_CLR = 3'd7
    } npc_op_e;

    // status bit positions that the condition logic decodes
    localparam int unsigned FLAG_N = 2;
    localparam int unsigned FLAG_V = 3;
    localparam int unsigned FLAG_S = 4;

    localparam logic [1:0] CYC_ONE   = 2'd1;
    localparam logic [1:0] CYC_TWO   = 2'd2;
    localparam logic [1:0] CYC_THREE = 2'd3;

endpackage

// File: rtl/npc_cond.sv
module npc_cond
    import npc_pkg::*;
#(
    parameter int SR_W  = 8,
    localparam int SEL_W = $clog2(SR_W)
) (
    input  npc_op_e          op_i,
    input  logic [SR_W-1:0]  sreg_i,
    input  logic [SEL_W-1:0] bit_sel_i,
    input  logic             test_bit_i,
    output logic             cond_o
);

    logic flag_sel;

    // the sign flag is rebuilt from N and V rather than read from storage
    always_comb begin
        if (bit_sel_i == SEL_W'(FLAG_S)) begin
            flag_sel = sreg_i[FLAG_N] ^ sreg_i[FLAG_V];
        end else begin
            flag_sel = sreg_i[bit_sel_i];
        end
    end

    always_comb begin
        unique case (op_i)
            OP_SEQ:    cond_o = 1'b0;
            OP_RJMP,
            OP_RCALL,
            OP_IJMP:   cond_o = 1'b1;
            OP_BR_SET: cond_o = flag_sel;
            OP_BR_CLR: cond_o = ~flag_sel;
            OP_SK_SET: cond_o = test_bit_i;
            OP_SK_CLR: cond_o = ~test_bit_i;
            default:   cond_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/npc_target.sv
module npc_target #(
    parameter int PC_W   = 16,
    parameter int DISP_W = 12
) (
    input  logic [PC_W-1:0]   pc_i,
    input  logic [DISP_W-1:0] disp_i,
    output logic [PC_W-1:0]   seq_o,
    output logic [PC_W-1:0]   rel_o,
    output logic [PC_W-1:0]   skip1_o,
    output logic [PC_W-1:0]   skip2_o
);

    logic [PC_W-1:0] disp_ext;

    generate
        if (PC_W > DISP_W) begin : g_ext
            assign disp_ext = {{(PC_W-DISP_W){disp_i[DISP_W-1]}}, disp_i};
        end else begin : g_trunc
            assign disp_ext = disp_i[PC_W-1:0];
        end
    endgenerate

    assign seq_o   = pc_i + PC_W'(1);
    assign rel_o   = seq_o + disp_ext;
    assign skip1_o = pc_i + PC_W'(2);
    assign skip2_o = pc_i + PC_W'(3);

endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int DISP_W = 12,
    parameter int SR_W   = 8,
    localparam int SEL_W = $clog2(SR_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [SR_W-1:0]   sreg_i,
    input  logic [2:0]        op_i,
    input  logic [DISP_W-1:0] disp_i,
    input  logic [SEL_W-1:0]  bit_sel_i,
    input  logic              test_bit_i,
    input  logic              next_two_word_i,
    input  logic [PC_W-1:0]   z_ptr_i,
    output logic [PC_W-1:0]   npc_o,
    output logic              taken_o,
    output logic [1:0]        cycles_o
);

    typedef struct packed {
        logic [PC_W-1:0] npc;
        logic            taken;
        logic [1:0]      cycles;
    } npc_state_t;

    npc_state_t state_d, state_q;
    npc_op_e    op;
    logic       cond;
    logic [PC_W-1:0] seq_pc, rel_pc, skip1_pc, skip2_pc;

    assign op = npc_op_e'(op_i);

    npc_cond #(.SR_W(SR_W)) u_cond (
        .op_i       (op),
        .sreg_i     (sreg_i),
        .bit_sel_i  (bit_sel_i),
        .test_bit_i (test_bit_i),
        .cond_o     (cond)
    );

    npc_target #(.PC_W(PC_W), .DISP_W(DISP_W)) u_target (
        .pc_i    (pc_i),
        .disp_i  (disp_i),
        .seq_o   (seq_pc),
        .rel_o   (rel_pc),
        .skip1_o (skip1_pc),
        .skip2_o (skip2_pc)
    );

    always_comb begin
        state_d.npc    = seq_pc;
        state_d.taken  = 1'b0;
        state_d.cycles = CYC_ONE;
        unique case (op)
            OP_RJMP: begin
                state_d.npc    = rel_pc;
                state_d.taken  = 1'b1;
                state_d.cycles = CYC_TWO;
            end
            OP_RCALL: begin
                state_d.npc    = rel_pc;
                state_d.taken  = 1'b1;
                state_d.cycles = CYC_THREE;
            end
            OP_IJMP: begin
                state_d.npc    = z_ptr_i;
                state_d.taken  = 1'b1;
                state_d.cycles = CYC_TWO;
            end
            OP_BR_SET, OP_BR_CLR: begin
                if (cond) begin
                    state_d.npc    = rel_pc;
                    state_d.taken  = 1'b1;
                    state_d.cycles = CYC_TWO;
                end
            end
            OP_SK_SET, OP_SK_CLR: begin
                if (cond) begin
                    state_d.taken = 1'b1;
                    if (next_two_word_i) begin
                        state_d.npc    = skip2_pc;
                        state_d.cycles = CYC_THREE;
                    end else begin
                        state_d.npc    = skip1_pc;
                        state_d.cycles = CYC_TWO;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign npc_o    = state_q.npc;
    assign taken_o  = state_q.taken;
    assign cycles_o = state_q.cycles;

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
    parameter int PC_W   = 16,
    parameter int DISP_W = 12,
    parameter int SR_W   = 8,
    localparam int SEL_W = $clog2(SR_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PC_W-1:0]   pc_i,
    input logic [SR_W-1:0]   sreg_i,
    input logic [2:0]        op_i,
    input logic [DISP_W-1:0] disp_i,
    input logic [SEL_W-1:0]  bit_sel_i,
    input logic              test_bit_i,
    input logic              next_two_word_i,
    input logic [PC_W-1:0]   z_ptr_i,
    input logic [PC_W-1:0]   npc_o,
    input logic              taken_o,
    input logic [1:0]        cycles_o
);

    logic            past_ok;
    logic [PC_W-1:0] exp_seq, exp_rel, exp_skip;
    logic            nv_sign;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assign exp_seq  = pc_i + PC_W'(1);
    assign exp_rel  = pc_i + PC_W'($signed(disp_i)) + PC_W'(1);
    assign exp_skip = pc_i + (next_two_word_i ? PC_W'(3) : PC_W'(2));
    assign nv_sign  = sreg_i[2] ^ sreg_i[3];

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |-> (npc_o == '0 && !taken_o && cycles_o == 2'd0));

    p_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(op_i) == 3'd0) |->
        (npc_o == $past(exp_seq) && !taken_o && cycles_o == 2'd1));

    p_rel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && ($past(op_i) == 3'd1 || $past(op_i) == 3'd2)) |->
        (taken_o && npc_o == $past(exp_rel)));

    p_ijmp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(op_i) == 3'd3) |->
        (taken_o && npc_o == $past(z_ptr_i) && cycles_o == 2'd2));

    p_taken_cycles_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && taken_o) |-> (cycles_o >= 2'd2));

    p_not_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !taken_o) |-> (cycles_o == 2'd1 && npc_o == $past(exp_seq)));

    p_sign_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(op_i) == 3'd4 && $past(bit_sel_i) == SEL_W'(4)) |->
        (taken_o == $past(nv_sign)));

    p_skip_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(op_i) >= 3'd6 && taken_o) |->
        (npc_o == $past(exp_skip)));

endmodule

bind npc_unit npc_unit_chk #(.PC_W(PC_W), .DISP_W(DISP_W), .SR_W(SR_W)) u_chk (.*);

// File: tb/sim_npc_unit.sv
`timescale 1ns/1ps
module sim_npc_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] pc_i, z_ptr_i, npc_o;
    logic [7:0]  sreg_i;
    logic [2:0]  op_i, bit_sel_i;
    logic [11:0] disp_i;
    logic        test_bit_i, next_two_word_i, taken_o;
    logic [1:0]  cycles_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    npc_unit u0 (
        .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .sreg_i(sreg_i), .op_i(op_i),
        .disp_i(disp_i), .bit_sel_i(bit_sel_i), .test_bit_i(test_bit_i),
        .next_two_word_i(next_two_word_i), .z_ptr_i(z_ptr_i),
        .npc_o(npc_o), .taken_o(taken_o), .cycles_o(cycles_o)
    );

    function automatic logic [15:0] rel(input logic [15:0] pc, input logic [11:0] k);
        int s;
        s = int'($signed(k));
        return 16'(int'(pc) + s + 1);
    endfunction

    task automatic check(input string req, input logic [15:0] en, input logic et,
                         input logic [1:0] ec);
        n_chk++;
        if (npc_o !== en || taken_o !== et || cycles_o !== ec) begin
            n_fail++;
            $display("FAIL %s: npc=%h taken=%b cyc=%0d, expected npc=%h taken=%b cyc=%0d",
                     req, npc_o, taken_o, cycles_o, en, et, ec);
        end
    endtask

    task automatic drive(input logic [2:0] op, input logic [15:0] pc, input logic [7:0] sr,
                         input logic [11:0] k, input logic [2:0] sel, input logic tb,
                         input logic two, input logic [15:0] z);
        op_i = op; pc_i = pc; sreg_i = sr; disp_i = k;
        bit_sel_i = sel; test_bit_i = tb; next_two_word_i = two; z_ptr_i = z;
    endtask

    task automatic step(input string req, input logic [2:0] op, input logic [15:0] pc,
                        input logic [7:0] sr, input logic [11:0] k, input logic [2:0] sel,
                        input logic tb, input logic two, input logic [15:0] z,
                        input logic [15:0] en, input logic et, input logic [1:0] ec);
        @(negedge clk);
        drive(op, pc, sr, k, sel, tb, two, z);
        @(negedge clk);
        check(req, en, et, ec);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        drive(3'd1, 16'h1234, 8'hFF, 12'h055, 3'd0, 1'b1, 1'b1, 16'hAAAA);
        repeat (3) @(negedge clk);
        check("R1 reset", 16'h0000, 1'b0, 2'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_seq();
        step("R3 sequential", 3'd0, 16'h0040, 8'h00, 12'h123, 3'd0, 1'b0, 1'b0, 16'h0, 16'h0041, 1'b0, 2'd1);
        step("R9 sequential wrap", 3'd0, 16'hFFFF, 8'hFF, 12'h000, 3'd0, 1'b1, 1'b0, 16'h0, 16'h0000, 1'b0, 2'd1);
    endtask

    task automatic t_latency();
        step("R2 setup", 3'd3, 16'h0010, 8'h00, 12'h000, 3'd0, 1'b0, 1'b0, 16'h5A5A, 16'h5A5A, 1'b1, 2'd2);
        @(negedge clk);
        drive(3'd0, 16'h0300, 8'h00, 12'h000, 3'd0, 1'b0, 1'b0, 16'h0);
        #1;
        check("R2 hold before edge", 16'h5A5A, 1'b1, 2'd2);
        @(negedge clk);
        check("R2 after edge", 16'h0301, 1'b0, 2'd1);
    endtask

    task automatic t_jumps();
        step("R4 rjmp forward", 3'd1, 16'h0100, 8'h00, 12'h010, 3'd0, 1'b0, 1'b0, 16'h0, rel(16'h0100, 12'h010), 1'b1, 2'd2);
        step("R4 rcall backward", 3'd2, 16'h0100, 8'h00, 12'hFF0, 3'd0, 1'b0, 1'b0, 16'h0, rel(16'h0100, 12'hFF0), 1'b1, 2'd3);
        step("R9 most negative k", 3'd1, 16'h0005, 8'h00, 12'h800, 3'd0, 1'b0, 1'b0, 16'h0, rel(16'h0005, 12'h800), 1'b1, 2'd2);
        step("R9 wrap below zero", 3'd1, 16'h0002, 8'h00, 12'hFFC, 3'd0, 1'b0, 1'b0, 16'h0, 16'hFFFF, 1'b1, 2'd2);
        step("R9 wrap past top", 3'd2, 16'hFFF0, 8'h00, 12'h7FF, 3'd0, 1'b0, 1'b0, 16'h0, rel(16'hFFF0, 12'h7FF), 1'b1, 2'd3);
    endtask

    task automatic t_ijmp();
        step("R5 indirect", 3'd3, 16'h0777, 8'h00, 12'h044, 3'd0, 1'b0, 1'b1, 16'hBEEF, 16'hBEEF, 1'b1, 2'd2);
    endtask

    task automatic t_branch();
        for (int b = 0; b < 8; b++) begin
            if (b == 4) continue;
            step("R6 br-set taken", 3'd4, 16'h0400, 8'(1 << b), 12'h020, 3'(b), 1'b0, 1'b0, 16'h0, rel(16'h0400, 12'h020), 1'b1, 2'd2);
            step("R6 br-clr not", 3'd5, 16'h0400, 8'(1 << b), 12'h020, 3'(b), 1'b0, 1'b0, 16'h0, 16'h0401, 1'b0, 2'd1);
            step("R6 br-set not", 3'd4, 16'h0400, ~8'(1 << b), 12'hFE0, 3'(b), 1'b0, 1'b0, 16'h0, 16'h0401, 1'b0, 2'd1);
            step("R6 br-clr taken", 3'd5, 16'h0400, ~8'(1 << b), 12'hFE0, 3'(b), 1'b0, 1'b0, 16'h0, rel(16'h0400, 12'hFE0), 1'b1, 2'd2);
        end
    endtask

    task automatic t_signed();
        // N=1 V=0, stored S=0: less-than is true
        step("R7 less-than taken", 3'd4, 16'h0500, 8'h04, 12'h008, 3'd4, 1'b0, 1'b0, 16'h0, rel(16'h0500, 12'h008), 1'b1, 2'd2);
        step("R7 greater-eq not", 3'd5, 16'h0500, 8'h04, 12'h008, 3'd4, 1'b0, 1'b0, 16'h0, 16'h0501, 1'b0, 2'd1);
        // N=1 V=1, stored S=1: greater-or-equal is true
        step("R7 less-than not", 3'd4, 16'h0500, 8'h1C, 12'h008, 3'd4, 1'b0, 1'b0, 16'h0, 16'h0501, 1'b0, 2'd1);
        step("R7 greater-eq taken", 3'd5, 16'h0500, 8'h1C, 12'h008, 3'd4, 1'b0, 1'b0, 16'h0, rel(16'h0500, 12'h008), 1'b1, 2'd2);
        // same-or-higher is branch on C clear
        step("R6 same-or-higher", 3'd5, 16'h0500, 8'hFE, 12'h003, 3'd0, 1'b0, 1'b0, 16'h0, 16'h0504, 1'b1, 2'd2);
    endtask

    task automatic t_skip();
        step("R8 skip one word", 3'd6, 16'h0200, 8'h00, 12'h000, 3'd0, 1'b1, 1'b0, 16'h0, 16'h0202, 1'b1, 2'd2);
        step("R8 skip two words", 3'd6, 16'h0200, 8'h00, 12'h000, 3'd0, 1'b1, 1'b1, 16'h0, 16'h0203, 1'b1, 2'd3);
        step("R8 skip-set not", 3'd6, 16'h0200, 8'h00, 12'h000, 3'd0, 1'b0, 1'b1, 16'h0, 16'h0201, 1'b0, 2'd1);
        step("R8 skip-clr two words", 3'd7, 16'h0200, 8'hFF, 12'h000, 3'd0, 1'b0, 1'b1, 16'h0, 16'h0203, 1'b1, 2'd3);
        step("R8 skip-clr not", 3'd7, 16'h0200, 8'h00, 12'h000, 3'd0, 1'b1, 1'b0, 16'h0, 16'h0201, 1'b0, 2'd1);
        step("R9 skip wrap", 3'd7, 16'hFFFE, 8'h00, 12'h000, 3'd0, 1'b0, 1'b1, 16'h0, 16'h0001, 1'b1, 2'd3);
    endtask

    task automatic t_size_ignored();
        step("R10 rjmp two-word flag", 3'd1, 16'h0600, 8'h00, 12'h004, 3'd0, 1'b1, 1'b1, 16'h0, 16'h0605, 1'b1, 2'd2);
        step("R10 seq two-word flag", 3'd0, 16'h0600, 8'h00, 12'h004, 3'd0, 1'b1, 1'b1, 16'h0, 16'h0601, 1'b0, 2'd1);
        step("R10 branch two-word flag", 3'd4, 16'h0600, 8'h01, 12'h004, 3'd0, 1'b0, 1'b1, 16'h0, 16'h0605, 1'b1, 2'd2);
    endtask

    initial begin
        t_reset();
        t_seq();
        t_latency();
        t_jumps();
        t_ijmp();
        t_branch();
        t_signed();
        t_skip();
        t_size_ignored();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule